// File: doc/BRIEF.md
# Processor Status Byte with Interrupt Acceptance

This block holds the 8-bit status byte of a small microcontroller core and decides, cycle by cycle, whether a pending interrupt is taken. The byte packs the interrupt enable, zero, auxiliary-carry and carry flags, a two-bit register-bank select and an in-service priority bit. The core's ALU writes the arithmetic flags through per-flag enables. The sequencer issues enable/disable commands, bank-select writes, push strobes and restore strobes. The interrupt controller presents one maskable request, with its mask and priority, plus a non-maskable request.

When a request is taken, the block emits a one-cycle acknowledge. At the same clock edge it clears the interrupt enable and updates the in-service priority bit. It also presents the byte as it stood before that update on a save port, so the stack logic can write it. A push strobe uses the same save port. A restore strobe reloads the byte from the value popped off the stack. Bit 2 is reserved, always reads 0, and cannot be set.

Top module: `psw_irq_gate`

## Requirements
- R1: After reset `psw_byte` is 0x02 (only the in-service priority bit set), `bank_sel` is 0, and `irq_ack`, `nmi_ack` and `save_valid` are 0.
- R2: The status byte is laid out from bit 7 down to bit 0 as: interrupt enable, zero, bank bit 1, auxiliary carry, bank bit 0, reserved, in-service priority, carry. The reserved bit 2 always reads 0, even after a restore of a byte with bit 2 set.
- R3: With `alu_we_z` high, the zero flag becomes 1 if `alu_result` is all zeros and 0 otherwise. With `alu_we_ac` or `alu_we_cy` high, that flag loads `alu_ac` or `alu_cy`. A flag whose enable is low keeps its value.
- R4: `ie_set` sets the interrupt enable bit one cycle later and `ie_clr` clears it. When both are high together, the clear wins.
- R5: A maskable request is taken only if all of these hold: the interrupt enable bit is 1, `irq_req` is high, `irq_mask` is low, and either `irq_lo_prio` is 0 (high priority) or the in-service priority bit is 1. Otherwise no `irq_ack` follows and the byte is unchanged.
- R6: When a maskable request is taken in cycle t, then in cycle t+1 `irq_ack` and `save_valid` are high for one cycle and `save_byte` equals the byte from cycle t. In the same cycle t+1 the interrupt enable bit reads 0 and the in-service priority bit equals the `irq_lo_prio` value from cycle t.
- R7: `nmi_req` is taken whatever the interrupt enable bit holds. It wins over a simultaneous maskable request and clears the interrupt enable bit. It leaves the in-service priority bit unchanged, and it produces `nmi_ack` and a save of the pre-update byte one cycle later.
- R8: `push_stb` gives `save_valid` one cycle later, with `save_byte` equal to the byte present when the strobe was high. The status byte itself is not altered.
- R9: `restore_stb` loads `restore_byte`, with bit 2 forced to 0, one cycle later. The restore overrides enable/disable commands, ALU flag writes and bank writes in the same cycle. No interrupt is taken in a cycle with `restore_stb` high.
- R10: If a request is taken in the same cycle as `ie_set`, the interrupt enable bit still reads 0 afterwards.
- R11: `rbs_we` loads `rbs_val[1]` into bit 5 and `rbs_val[0]` into bit 3. `bank_sel` always equals {bit 5, bit 3} of `psw_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_result | input | DATA_W | ALU result used for zero detection |
| alu_we_z | input | 1 | Write enable for the zero flag |
| alu_we_ac | input | 1 | Write enable for the auxiliary-carry flag |
| alu_we_cy | input | 1 | Write enable for the carry flag |
| alu_ac | input | 1 | New auxiliary-carry value |
| alu_cy | input | 1 | New carry value |
| rbs_we | input | 1 | Register-bank select write enable |
| rbs_val | input | 2 | New register-bank select value |
| ie_set | input | 1 | Enable-interrupts command |
| ie_clr | input | 1 | Disable-interrupts command |
| push_stb | input | 1 | Request to save the status byte |
| restore_stb | input | 1 | Reload the status byte from `restore_byte` |
| restore_byte | input | 8 | Byte popped from the stack |
| irq_req | input | 1 | Pending maskable request |
| irq_mask | input | 1 | Mask for the maskable request (1 blocks it) |
| irq_lo_prio | input | 1 | Priority of the request (1 = low) |
| nmi_req | input | 1 | Non-maskable request |
| psw_byte | output | 8 | Packed status byte |
| bank_sel | output | 2 | Register-bank select |
| irq_ack | output | 1 | Maskable request taken (one-cycle pulse) |
| nmi_ack | output | 1 | Non-maskable request taken (one-cycle pulse) |
| save_valid | output | 1 | `save_byte` is to be written to the stack |
| save_byte | output | 8 | Byte to save |

## Verification
The hardest situation to reach is a maskable request that arrives exactly when the state would let it through but another event competes in the same cycle. Examples are a restore strobe, an enable command, or a non-maskable request, and the case where the in-service priority bit has been cleared by an earlier high-priority acceptance. The bench uses the restore path to load exact byte values, including interrupt enable 1 with the in-service bit 0, in a single cycle. It then raises the request together with the competing strobe on the very next cycle. Because the pre-update byte reappears on the save port, the bench can separate the state before acceptance from the state after it.

// File: rtl/psw_pkg.sv
package psw_pkg;

  localparam int PSW_W  = 8;
  localparam int BANK_W = 2;

  // Field order is architectural: software and the stack path decode it.
  typedef struct packed {
    logic ie;
    logic z;
    logic rbs1;
    logic ac;
    logic rbs0;
    logic rsvd;
    logic isp;
    logic cy;
  } psw_t;

  localparam psw_t PSW_RESET = '{ie: 1'b0, z: 1'b0, rbs1: 1'b0, ac: 1'b0,
                                 rbs0: 1'b0, rsvd: 1'b0, isp: 1'b1, cy: 1'b0};

  function automatic psw_t psw_clean(input logic [PSW_W-1:0] raw);
    psw_t p;
    p      = psw_t'(raw);
    p.rsvd = 1'b0;
    return p;
  endfunction

endpackage

// File: rtl/psw_accept_logic.sv
module psw_accept_logic (
  input  logic ie,
  input  logic isp,
  input  logic hold,
  input  logic irq_req,
  input  logic irq_mask,
  input  logic irq_lo_prio,
  input  logic nmi_req,
  output logic take_irq,
  output logic take_nmi
);

  logic prio_ok;

  always_comb begin
    prio_ok  = !irq_lo_prio || isp;
    take_nmi = nmi_req && !hold;
    take_irq = irq_req && !irq_mask && ie && prio_ok && !nmi_req && !hold;
  end

endmodule

// File: rtl/psw_flag_file.sv
module psw_flag_file
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DATA_W-1:0]     alu_result,
  input  logic                  alu_we_z,
  input  logic                  alu_we_ac,
  input  logic                  alu_we_cy,
  input  logic                  alu_ac,
  input  logic                  alu_cy,
  input  logic                  rbs_we,
  input  logic [BANK_W-1:0]     rbs_val,
  input  logic                  ie_set,
  input  logic                  ie_clr,
  input  logic                  restore_stb,
  input  logic [PSW_W-1:0]      restore_byte,
  input  logic                  take_irq,
  input  logic                  take_nmi,
  input  logic                  irq_lo_prio,
  output psw_t                  state
);

  psw_t nxt;
  logic res_zero;

  always_comb begin
    res_zero = ~|alu_result;
    nxt      = state;
    if (restore_stb) begin
      nxt = psw_clean(restore_byte);
    end else begin
      if (alu_we_z)  nxt.z  = res_zero;
      if (alu_we_ac) nxt.ac = alu_ac;
      if (alu_we_cy) nxt.cy = alu_cy;
      if (rbs_we) begin
        nxt.rbs1 = rbs_val[1];
        nxt.rbs0 = rbs_val[0];
      end
      if (ie_clr)      nxt.ie = 1'b0;
      else if (ie_set) nxt.ie = 1'b1;
      if (take_irq || take_nmi) nxt.ie = 1'b0;
      if (take_irq) nxt.isp = irq_lo_prio;
      nxt.rsvd = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PSW_RESET;
    else     state <= nxt;
  end

endmodule

// File: rtl/psw_save_port.sv
module psw_save_port
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             push_stb,
  input  logic             take_irq,
  input  logic             take_nmi,
  input  psw_t             cur,
  output logic             save_valid,
  output logic [PSW_W-1:0] save_byte,
  output logic             irq_ack,
  output logic             nmi_ack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      save_valid <= 1'b0;
      save_byte  <= '0;
      irq_ack    <= 1'b0;
      nmi_ack    <= 1'b0;
    end else begin
      save_valid <= push_stb || take_irq || take_nmi;
      irq_ack    <= take_irq;
      nmi_ack    <= take_nmi;
      if (push_stb || take_irq || take_nmi) save_byte <= cur;
    end
  end

endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_we_z,
  input  logic              alu_we_ac,
  input  logic              alu_we_cy,
  input  logic              alu_ac,
  input  logic              alu_cy,
  input  logic              rbs_we,
  input  logic [1:0]        rbs_val,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              push_stb,
  input  logic              restore_stb,
  input  logic [7:0]        restore_byte,
  input  logic              irq_req,
  input  logic              irq_mask,
  input  logic              irq_lo_prio,
  input  logic              nmi_req,
  output logic [7:0]        psw_byte,
  output logic [1:0]        bank_sel,
  output logic              irq_ack,
  output logic              nmi_ack,
  output logic              save_valid,
  output logic [7:0]        save_byte
);

  psw_t state;
  logic take_irq;
  logic take_nmi;

  psw_accept_logic u_accept (
    .ie          (state.ie),
    .isp         (state.isp),
    .hold        (restore_stb),
    .irq_req     (irq_req),
    .irq_mask    (irq_mask),
    .irq_lo_prio (irq_lo_prio),
    .nmi_req     (nmi_req),
    .take_irq    (take_irq),
    .take_nmi    (take_nmi)
  );

  psw_flag_file #(.DATA_W(DATA_W)) u_flags (
    .clk          (clk),
    .rst          (rst),
    .alu_result   (alu_result),
    .alu_we_z     (alu_we_z),
    .alu_we_ac    (alu_we_ac),
    .alu_we_cy    (alu_we_cy),
    .alu_ac       (alu_ac),
    .alu_cy       (alu_cy),
    .rbs_we       (rbs_we),
    .rbs_val      (rbs_val),
    .ie_set       (ie_set),
    .ie_clr       (ie_clr),
    .restore_stb  (restore_stb),
    .restore_byte (restore_byte),
    .take_irq     (take_irq),
    .take_nmi     (take_nmi),
    .irq_lo_prio  (irq_lo_prio),
    .state        (state)
  );

  psw_save_port u_save (
    .clk        (clk),
    .rst        (rst),
    .push_stb   (push_stb),
    .take_irq   (take_irq),
    .take_nmi   (take_nmi),
    .cur        (state),
    .save_valid (save_valid),
    .save_byte  (save_byte),
    .irq_ack    (irq_ack),
    .nmi_ack    (nmi_ack)
  );

  always_comb begin
    psw_byte = state;
    bank_sel = {state.rbs1, state.rbs0};
  end

endmodule

// File: rtl/psw_irq_gate_chk.sv
module psw_irq_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       ie_set,
  input logic       ie_clr,
  input logic       restore_stb,
  input logic [7:0] restore_byte,
  input logic       irq_req,
  input logic       irq_mask,
  input logic [7:0] psw_byte,
  input logic [1:0] bank_sel,
  input logic       irq_ack,
  input logic       nmi_ack,
  input logic       save_valid,
  input logic [7:0] save_byte
);

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (rst)
    !psw_byte[2]);  // R2

  AST_IE_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    ie_set && !ie_clr && !restore_stb |=> psw_byte[7] || irq_ack || nmi_ack);  // R4

  AST_IRQ_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(irq_req && !irq_mask && psw_byte[7]));  // R5

  AST_ACK_DROPS_IE: assert property (@(posedge clk) disable iff (rst)
    irq_ack || nmi_ack |-> !psw_byte[7] && save_valid);  // R6

  AST_ACK_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    !(irq_ack && nmi_ack));  // R7

  AST_SAVE_PRIOR: assert property (@(posedge clk) disable iff (rst)
    save_valid |-> save_byte == $past(psw_byte));  // R8

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    restore_stb |=> psw_byte == ($past(restore_byte) & 8'hFB));  // R9

  AST_BANK_TRACKS: assert property (@(posedge clk) disable iff (rst)
    bank_sel == {psw_byte[5], psw_byte[3]});  // R11

endmodule

bind psw_irq_gate psw_irq_gate_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ie_set       (ie_set),
  .ie_clr       (ie_clr),
  .restore_stb  (restore_stb),
  .restore_byte (restore_byte),
  .irq_req      (irq_req),
  .irq_mask     (irq_mask),
  .psw_byte     (psw_byte),
  .bank_sel     (bank_sel),
  .irq_ack      (irq_ack),
  .nmi_ack      (nmi_ack),
  .save_valid   (save_valid),
  .save_byte    (save_byte)
);

// File: tb/psw_irq_gate_bench.sv
module psw_irq_gate_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] alu_result = '0;
  logic          alu_we_z = 1'b0, alu_we_ac = 1'b0, alu_we_cy = 1'b0;
  logic          alu_ac = 1'b0, alu_cy = 1'b0;
  logic          rbs_we = 1'b0;
  logic [1:0]    rbs_val = '0;
  logic          ie_set = 1'b0, ie_clr = 1'b0;
  logic          push_stb = 1'b0, restore_stb = 1'b0;
  logic [7:0]    restore_byte = '0;
  logic          irq_req = 1'b0, irq_mask = 1'b0, irq_lo_prio = 1'b0, nmi_req = 1'b0;
  logic [7:0]    psw_byte;
  logic [1:0]    bank_sel;
  logic          irq_ack, nmi_ack, save_valid;
  logic [7:0]    save_byte;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  psw_irq_gate #(.DATA_W(DW)) u_psw_irq_gate (
    .clk(clk), .rst(rst), .alu_result(alu_result), .alu_we_z(alu_we_z),
    .alu_we_ac(alu_we_ac), .alu_we_cy(alu_we_cy), .alu_ac(alu_ac), .alu_cy(alu_cy),
    .rbs_we(rbs_we), .rbs_val(rbs_val), .ie_set(ie_set), .ie_clr(ie_clr),
    .push_stb(push_stb), .restore_stb(restore_stb), .restore_byte(restore_byte),
    .irq_req(irq_req), .irq_mask(irq_mask), .irq_lo_prio(irq_lo_prio),
    .nmi_req(nmi_req), .psw_byte(psw_byte), .bank_sel(bank_sel),
    .irq_ack(irq_ack), .nmi_ack(nmi_ack), .save_valid(save_valid),
    .save_byte(save_byte)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    alu_we_z = 0; alu_we_ac = 0; alu_we_cy = 0; rbs_we = 0;
    ie_set = 0; ie_clr = 0; push_stb = 0; restore_stb = 0;
    irq_req = 0; irq_mask = 0; irq_lo_prio = 0; nmi_req = 0;
  endtask

  task automatic load(input logic [7:0] b);
    idle();
    restore_stb = 1; restore_byte = b;
    tick();
    idle();
  endtask

  task automatic t_reset();
    chk(psw_byte, 8'h02, "R1 reset byte");
    chk({6'd0, bank_sel}, 8'h00, "R1 reset bank");
    chk({5'd0, irq_ack, nmi_ack, save_valid}, 8'h00, "R1 reset pulses");
  endtask

  task automatic t_alu();
    alu_result = 8'h00; alu_we_z = 1; alu_we_ac = 1; alu_we_cy = 1; alu_ac = 1; alu_cy = 1;
    tick(); idle();
    chk(psw_byte, 8'h53, "R3 zero result sets Z, AC, CY");
    alu_result = 8'h05; alu_we_z = 1;
    tick(); idle();
    chk(psw_byte, 8'h13, "R3 nonzero result clears Z");
    alu_result = 8'h00; alu_ac = 0; alu_cy = 0;
    tick(); idle();
    chk(psw_byte, 8'h13, "R3 no enable keeps flags");
    alu_we_ac = 1; alu_we_cy = 1;
    tick(); idle();
    chk(psw_byte, 8'h02, "R3 clear AC and CY");
  endtask

  task automatic t_bank();
    rbs_we = 1; rbs_val = 2'b10;
    tick(); idle();
    chk(psw_byte, 8'h22, "R11 bank bit1 at bit5");
    chk({6'd0, bank_sel}, 8'h02, "R11 bank_sel 2");
    rbs_we = 1; rbs_val = 2'b01;
    tick(); idle();
    chk(psw_byte, 8'h0A, "R11 bank bit0 at bit3");
    chk({6'd0, bank_sel}, 8'h01, "R11 bank_sel 1");
    rbs_we = 1; rbs_val = 2'b00;
    tick(); idle();
  endtask

  task automatic t_ie();
    ie_set = 1;
    tick(); idle();
    chk(psw_byte, 8'h82, "R4 enable sets bit7");
    ie_set = 1; ie_clr = 1;
    tick(); idle();
    chk(psw_byte, 8'h02, "R4 clear wins over set");
  endtask

  task automatic t_restore();
    load(8'hFF);
    chk(psw_byte, 8'hFB, "R2 restore drops bit2");
    chk({6'd0, bank_sel}, 8'h03, "R11 bank from restore");
    restore_stb = 1; restore_byte = 8'h04; ie_set = 1; alu_we_cy = 1; alu_cy = 1;
    tick(); idle();
    chk(psw_byte, 8'h00, "R9 restore beats enable and ALU");
    load(8'h02);
  endtask

  task automatic t_push();
    load(8'h43);
    push_stb = 1;
    tick(); idle();
    chk({7'd0, save_valid}, 8'h01, "R8 push gives save_valid");
    chk(save_byte, 8'h43, "R8 push saves current byte");
    chk(psw_byte, 8'h43, "R8 push leaves byte");
    tick();
    chk({7'd0, save_valid}, 8'h00, "R8 save_valid one cycle");
  endtask

  task automatic t_blocked();
    load(8'h02);
    irq_req = 1;
    tick(); idle();
    chk({7'd0, irq_ack}, 8'h00, "R5 blocked when IE=0");
    load(8'h82);
    irq_req = 1; irq_mask = 1;
    tick(); idle();
    chk({7'd0, irq_ack}, 8'h00, "R5 blocked when masked");
    chk(psw_byte, 8'h82, "R5 masked leaves byte");
    load(8'h80);
    irq_req = 1; irq_lo_prio = 1;
    tick(); idle();
    chk({7'd0, irq_ack}, 8'h00, "R5 low prio blocked with ISP=0");
    chk(psw_byte, 8'h80, "R5 low prio blocked leaves byte");
  endtask

  task automatic t_take_hi();
    load(8'h83);
    irq_req = 1; irq_lo_prio = 0;
    tick(); idle();
    chk({6'd0, irq_ack, save_valid}, 8'h03, "R6 ack and save pulse");
    chk(save_byte, 8'h83, "R6 saves pre-accept byte");
    chk(psw_byte, 8'h01, "R6 IE cleared ISP from high prio");
    tick();
    chk({6'd0, irq_ack, save_valid}, 8'h00, "R6 pulses last one cycle");
  endtask

  task automatic t_take_lo();
    load(8'h82);
    irq_req = 1; irq_lo_prio = 1;
    tick(); idle();
    chk({7'd0, irq_ack}, 8'h01, "R5 low prio taken with ISP=1");
    chk(psw_byte, 8'h02, "R6 ISP from low prio");
    chk(save_byte, 8'h82, "R6 saved byte");
    load(8'h80);
    irq_req = 1; irq_lo_prio = 0;
    tick(); idle();
    chk({7'd0, irq_ack}, 8'h01, "R5 high prio taken with ISP=0");
    chk(psw_byte, 8'h00, "R6 nested accept byte");
  endtask

  task automatic t_nmi();
    load(8'h00);
    nmi_req = 1;
    tick(); idle();
    chk({6'd0, nmi_ack, irq_ack}, 8'h02, "R7 nmi taken with IE=0");
    chk(save_byte, 8'h00, "R7 nmi save byte");
    load(8'h82);
    nmi_req = 1; irq_req = 1; irq_lo_prio = 0;
    tick(); idle();
    chk({6'd0, nmi_ack, irq_ack}, 8'h02, "R7 nmi wins over maskable");
    chk(psw_byte, 8'h02, "R7 nmi clears IE keeps ISP");
    chk(save_byte, 8'h82, "R7 nmi saves prior byte");
  endtask

  task automatic t_take_vs_set();
    load(8'h82);
    irq_req = 1; ie_set = 1;
    tick(); idle();
    chk({7'd0, irq_ack}, 8'h01, "R10 accepted with enable");
    chk(psw_byte, 8'h00, "R10 accept beats enable");
  endtask

  task automatic t_restore_holds();
    load(8'h82);
    restore_stb = 1; restore_byte = 8'h82; irq_req = 1;
    tick();
    restore_stb = 0;
    chk({7'd0, irq_ack}, 8'h00, "R9 no accept during restore");
    chk(psw_byte, 8'h82, "R9 byte after restore");
    tick(); idle();
    chk({7'd0, irq_ack}, 8'h01, "R9 accept after restore");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    t_reset();
    t_alu();
    t_bank();
    t_ie();
    t_restore();
    t_push();
    t_blocked();
    t_take_hi();
    t_take_lo();
    t_nmi();
    t_take_vs_set();
    t_restore_holds();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule